// File: doc/BRIEF.md
# Branch Resolution Unit

This block settles the outcome of a conditional branch in a 32-bit RISC pipeline that has a single branch delay slot. Decode supplies a small branch-kind code, and the register stage supplies the two source operands. Alongside them come the 16-bit immediate offset, the address of the branch instruction and the condition flag from the system coprocessor. From these inputs the block computes whether the branch is taken and where it goes. For the linking forms, it also produces the return address to be written into register 31.

The target address is always formed relative to the delay-slot instruction, which sits at the branch address plus 4. The offset is sign-extended, scaled by four and added to that address. The return address points past the delay slot, at the branch address plus 8. The two linking forms raise the link-write enable whether or not their condition holds.

All results are captured in one register stage and appear one clock after the request, marked by a valid strobe. Fetch redirection, flushing and the register-file write port belong to the surrounding pipeline.

Top module: `brx_resolve_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid`, `out_taken`, `out_link_we`, `out_target` and `out_link_data` are all cleared to 0 at that edge.
- R2: Kind 1 (equal) is taken when all 32 bits of `rs_val` and `rt_val` match; kind 2 (not equal) is taken when any bit differs.
- R3: Kinds 3, 4, 5 and 6 treat `rs_val` as two's complement: kind 3 is taken for rs <= 0, kind 4 for rs > 0, kind 5 for rs < 0, kind 6 for rs >= 0.
- R4: Kind 7 is taken for rs < 0 and kind 8 for rs >= 0; both always set `out_link_we` to 1, taken or not, and no other kind sets it.
- R5: For every accepted request, `out_link_data` equals `br_pc` + 8 (modulo 2^32).
- R6: For every accepted request, `out_target` equals `br_pc` + 4 + (sign-extended `offset` shifted left by two), modulo 2^32.
- R7: Kind 9 is taken when `cp0_cond` is 1, and kind 10 is taken when `cp0_cond` is 0.
- R8: Kind 0 (none) gives `out_taken` = 0 and `out_link_we` = 0.
- R9: Results appear one clock after a request is accepted, with `in_valid` high at that edge; `out_valid` then equals the `in_valid` sampled at the previous edge. An edge with `in_valid` low gives `out_taken` = 0 and `out_link_we` = 0.
- R10: Kind codes 11 to 15 behave like kind 0: the branch is not taken and no link write is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| kind | input | 4 | Branch kind code (see R2–R10) |
| rs_val | input | 32 | First source operand |
| rt_val | input | 32 | Second source operand |
| offset | input | 16 | Signed word offset from the instruction |
| br_pc | input | 32 | Address of the branch instruction |
| cp0_cond | input | 1 | Coprocessor condition flag |
| out_valid | output | 1 | Registered result valid |
| out_taken | output | 1 | Branch is taken |
| out_target | output | 32 | Branch target address |
| out_link_we | output | 1 | Write the return address to register 31 |
| out_link_data | output | 32 | Return address (branch address plus 8) |

## Verification
The assertions check the following on every cycle:
- the one-cycle latency of the valid strobe;
- the quiet outputs after an idle cycle;
- the address arithmetic for targets and return addresses;
- the unconditional link enable of the linking kinds;
- the silence of kind 0;
- the way the coprocessor flag drives kinds 9 and 10.

The bench's scenarios cover the other outcomes. These are the signed and unsigned corner outcomes of the compare kinds at 0, -1, 0x7FFFFFFF and 0x80000000, the sign extension of offsets 0x7FFF and 0x8000, and the behaviour of the unused kind codes.

// File: rtl/brx_pkg.sv
// Package: shared branch-kind encoding and result bundle for the branch
// resolution unit. Assumes a 4-bit kind field supplied by decode.
package brx_pkg;

    localparam int KIND_W = 4;

    typedef enum logic [KIND_W-1:0] {
        BK_NONE  = 4'd0,
        BK_EQ    = 4'd1,
        BK_NE    = 4'd2,
        BK_LEZ   = 4'd3,
        BK_GTZ   = 4'd4,
        BK_LTZ   = 4'd5,
        BK_GEZ   = 4'd6,
        BK_LTZL  = 4'd7,
        BK_GEZL  = 4'd8,
        BK_CPT   = 4'd9,
        BK_CPF   = 4'd10
    } brx_kind_e;

    typedef struct packed {
        logic        taken;
        logic        link_we;
        logic [31:0] target;
        logic [31:0] link_data;
    } brx_result_t;

endpackage

// File: rtl/brx_cond_eval.sv
// Module: brx_cond_eval
// Decides whether a branch is taken and whether it links, from the kind
// code, the operands and the coprocessor flag. Purely combinational.
// Assumes operands are two's complement of width DW; unknown kinds are inert.
module brx_cond_eval
    import brx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [KIND_W-1:0] kind,
    input  logic [DW-1:0]     rs_val,
    input  logic [DW-1:0]     rt_val,
    input  logic              cp0_cond,
    output logic              taken,
    output logic              link_we
);
    localparam int SIGN_BIT = DW - 1;

    logic rs_neg;
    logic rs_zero;
    logic ops_eq;

    // Operand flags shared by all compare kinds.
    always_comb begin
        rs_neg  = rs_val[SIGN_BIT];
        rs_zero = (rs_val == '0);
        ops_eq  = (rs_val == rt_val);
    end

    // Condition selection per kind; default keeps unknown codes inert.
    always_comb begin
        taken   = 1'b0;
        link_we = 1'b0;
        case (brx_kind_e'(kind))
            BK_EQ:   taken = ops_eq;
            BK_NE:   taken = !ops_eq;
            BK_LEZ:  taken = rs_neg || rs_zero;
            BK_GTZ:  taken = !rs_neg && !rs_zero;
            BK_LTZ:  taken = rs_neg;
            BK_GEZ:  taken = !rs_neg;
            BK_LTZL: begin
                taken   = rs_neg;
                link_we = 1'b1;
            end
            BK_GEZL: begin
                taken   = !rs_neg;
                link_we = 1'b1;
            end
            BK_CPT:  taken = cp0_cond;
            BK_CPF:  taken = !cp0_cond;
            default: begin
                taken   = 1'b0;
                link_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/brx_addr_gen.sv
// Module: brx_addr_gen
// Forms the branch target (delay-slot address plus scaled, sign-extended
// offset) and the return address past the delay slot. Combinational.
// Assumes byte addressing with INSN_BYTES-sized instructions.
module brx_addr_gen #(
    parameter int AW         = 32,
    parameter int OW         = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic [AW-1:0] br_pc,
    input  logic [OW-1:0] offset,
    output logic [AW-1:0] target,
    output logic [AW-1:0] link_data
);
    localparam int SHIFT   = $clog2(INSN_BYTES);
    localparam int EXT_W   = AW - OW - SHIFT;
    localparam logic [AW-1:0] SLOT_STEP = AW'(INSN_BYTES);
    localparam logic [AW-1:0] LINK_STEP = AW'(2 * INSN_BYTES);

    logic [AW-1:0] slot_pc;
    logic [AW-1:0] disp;

    // Sign-extend and scale the offset; fill low bits with zeros.
    generate
        if (SHIFT > 0) begin : g_scaled
            always_comb disp = {{EXT_W{offset[OW-1]}}, offset, {SHIFT{1'b0}}};
        end else begin : g_unscaled
            always_comb disp = {{EXT_W{offset[OW-1]}}, offset};
        end
    endgenerate

    // Target and return address arithmetic.
    always_comb begin
        slot_pc   = br_pc + SLOT_STEP;
        target    = slot_pc + disp;
        link_data = br_pc + LINK_STEP;
    end

endmodule

// File: rtl/brx_out_reg.sv
// Module: brx_out_reg
// Single register stage for the branch result with a valid strobe.
// Assumes synchronous active-low reset; taken/link are masked when idle.
module brx_out_reg
    import brx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  brx_result_t res_d,
    output logic        valid_q,
    output brx_result_t res_q
);
    // Capture the result; addresses hold while idle, flags drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q       <= in_valid;
            res_q.taken   <= in_valid && res_d.taken;
            res_q.link_we <= in_valid && res_d.link_we;
            if (in_valid) begin
                res_q.target    <= res_d.target;
                res_q.link_data <= res_d.link_data;
            end
        end
    end

endmodule

// File: rtl/brx_resolve_unit.sv
// Module: brx_resolve_unit (top)
// Resolves a decoded branch: taken flag, target, link enable and link
// address, registered once. Assumes 32-bit operands and addresses, a 16-bit
// offset, a single delay slot, and decode that drives a valid kind code.
module brx_resolve_unit
    import brx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [3:0]  kind,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    input  logic [15:0] offset,
    input  logic [31:0] br_pc,
    input  logic        cp0_cond,
    output logic        out_valid,
    output logic        out_taken,
    output logic [31:0] out_target,
    output logic        out_link_we,
    output logic [31:0] out_link_data
);
    localparam int DW = 32;
    localparam int OW = 16;

    brx_result_t res_c;
    brx_result_t res_r;

    brx_cond_eval #(.DW(DW)) u_cond (
        .kind     (kind),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .cp0_cond (cp0_cond),
        .taken    (res_c.taken),
        .link_we  (res_c.link_we)
    );

    brx_addr_gen #(.AW(DW), .OW(OW), .INSN_BYTES(4)) u_addr (
        .br_pc     (br_pc),
        .offset    (offset),
        .target    (res_c.target),
        .link_data (res_c.link_data)
    );

    brx_out_reg u_oreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .res_d    (res_c),
        .valid_q  (out_valid),
        .res_q    (res_r)
    );

    // Unpack the registered bundle onto the ports.
    always_comb begin
        out_taken     = res_r.taken;
        out_target    = res_r.target;
        out_link_we   = res_r.link_we;
        out_link_data = res_r.link_data;
    end

endmodule

// File: rtl/brx_resolve_chk.sv
// Module: brx_resolve_chk
// Port-level temporal checks for brx_resolve_unit, attached by bind.
module brx_resolve_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  kind,
    input logic [31:0] br_pc,
    input logic [15:0] offset,
    input logic        cp0_cond,
    input logic        out_valid,
    input logic        out_taken,
    input logic [31:0] out_target,
    input logic        out_link_we,
    input logic [31:0] out_link_data
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_taken && !out_link_we && out_target == '0 && out_link_data == '0)); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_taken && !out_link_we)); // R9

    AST_LINK_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (kind == 4'd7 || kind == 4'd8)) |=> out_link_we); // R4

    AST_LINK_KIND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind != 4'd7 && kind != 4'd8) |=> !out_link_we); // R4

    AST_LINK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_link_data == $past(br_pc) + 32'd8)); // R5

    AST_TARGET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_target == $past(br_pc) + 32'd4
                      + {{14{$past(offset[15])}}, $past(offset), 2'b00})); // R6

    AST_CP_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 4'd9) |=> (out_taken == $past(cp0_cond))); // R7

    AST_CP_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 4'd10) |=> (out_taken != $past(cp0_cond))); // R7

    AST_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 4'd0) |=> (!out_taken && !out_link_we)); // R8

endmodule

bind brx_resolve_unit brx_resolve_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .kind          (kind),
    .br_pc         (br_pc),
    .offset        (offset),
    .cp0_cond      (cp0_cond),
    .out_valid     (out_valid),
    .out_taken     (out_taken),
    .out_target    (out_target),
    .out_link_we   (out_link_we),
    .out_link_data (out_link_data)
);

// File: tb/brx_resolve_unit_tb_top.sv
// Bench: directed corner sweep plus seeded random requests, each result
// compared with values computed from the requirements.
module brx_resolve_unit_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  kind;
    logic [31:0] rs_val, rt_val, br_pc;
    logic [15:0] offset;
    logic        cp0_cond;
    logic        out_valid, out_taken, out_link_we;
    logic [31:0] out_target, out_link_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brx_resolve_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .kind(kind),
        .rs_val(rs_val), .rt_val(rt_val), .offset(offset), .br_pc(br_pc),
        .cp0_cond(cp0_cond), .out_valid(out_valid), .out_taken(out_taken),
        .out_target(out_target), .out_link_we(out_link_we),
        .out_link_data(out_link_data)
    );

    // Reference condition per R2, R3, R4, R7, R8, R10.
    function automatic bit ref_taken(input logic [3:0] k, input logic [31:0] a,
                                     input logic [31:0] b, input logic c);
        case (k)
            4'd1: return a == b;
            4'd2: return a != b;
            4'd3: return $signed(a) <= 0;
            4'd4: return $signed(a) > 0;
            4'd5, 4'd7: return $signed(a) < 0;
            4'd6, 4'd8: return $signed(a) >= 0;
            4'd9: return c;
            4'd10: return !c;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] k);
        case (k)
            4'd0: return "R8";
            4'd1, 4'd2: return "R2";
            4'd3, 4'd4, 4'd5, 4'd6: return "R3";
            4'd7, 4'd8: return "R4";
            4'd9, 4'd10: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one request at a falling edge, then check at the next falling edge.
    task automatic run_one(input logic [3:0] k, input logic [31:0] a,
                           input logic [31:0] b, input logic [15:0] off,
                           input logic [31:0] pc, input logic c);
        logic [31:0] exp_tgt;
        in_valid = 1'b1; kind = k; rs_val = a; rt_val = b;
        offset = off; br_pc = pc; cp0_cond = c;
        exp_tgt = pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
        @(negedge clk);
        check("R9", "valid", 32'(out_valid), 32'd1);
        check(req_of(k), "taken", 32'(out_taken), 32'(ref_taken(k, a, b, c)));
        check(req_of(k), "link_we", 32'(out_link_we),
              32'(k == 4'd7 || k == 4'd8));
        check("R6", "target", out_target, exp_tgt);
        check("R5", "link_data", out_link_data, pc + 32'd8);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] corners [4];
        logic [15:0] offs [2];
        corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
        corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
        offs[0] = 16'h7FFF; offs[1] = 16'h8000;
        void'($urandom(32'd20240611));

        rst_n = 1'b0; in_valid = 1'b1; kind = 4'd8; rs_val = '0; rt_val = '0;
        offset = 16'h1234; br_pc = 32'h1000; cp0_cond = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset clears everything even with a linking request presented.
        check("R1", "valid", 32'(out_valid), 32'd0);
        check("R1", "taken", 32'(out_taken), 32'd0);
        check("R1", "link_we", 32'(out_link_we), 32'd0);
        check("R1", "target", out_target, 32'd0);
        check("R1", "link_data", out_link_data, 32'd0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check("R9", "idle valid", 32'(out_valid), 32'd0);

        // Directed sweep of every kind code over the operand/offset corners.
        for (int k = 0; k < 16; k++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    for (int o = 0; o < 2; o++)
                        run_one(4'(k), corners[i], corners[j], offs[o],
                                32'hFFFF_FFF0 - 32'(k * 64), 1'(o));

        // R9: an idle cycle after a taken, linking request drops the flags.
        run_one(4'd8, 32'd5, 32'd0, 16'd1, 32'h400, 1'b0);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9", "idle valid", 32'(out_valid), 32'd0);
        check("R9", "idle taken", 32'(out_taken), 32'd0);
        check("R9", "idle link_we", 32'(out_link_we), 32'd0);

        // Seeded random requests mixing corner and arbitrary operands.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, b;
            a = ($urandom % 3 == 0) ? corners[$urandom % 4] : $urandom;
            b = ($urandom % 3 == 0) ? a : $urandom;
            run_one(4'($urandom % 16), a, b, 16'($urandom), $urandom, 1'($urandom));
            if ($urandom % 8 == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
                check("R9", "gap valid", 32'(out_valid), 32'd0);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule